// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block is the power-management unit of a small microcontroller. Software writes a power control register and a halt-release enable register over a byte-wide write bus. The block then drives an oscillator enable and a CPU clock gate. It has two sleep depths. Stop mode turns the oscillator off and leaves only on a fixed set of external events. Halt mode gates the CPU clock and leaves only on interrupts that software has enabled. Every wake clears both sleep bits in the same cycle. The CPU clock comes back only once the oscillator reports that it is stable.

All logic runs on an always-on clock, so wake events are seen while the system oscillator is stopped. Event inputs are level-sensitive and pass through a synchronizer of `SYNC_STAGES` flops. A wake out of halt records, in a sticky status vector, which enabled sources caused it. Software clears that vector with an acknowledge pulse.

There are four states. `PM_RUN` is the normal state. `PM_HALT` has the CPU clock gated and the oscillator running. `PM_STOP` has both off. `PM_OSCWAIT` has the oscillator on and the CPU clock still gated.

The transitions are:
- **enter-stop**: a power write in `PM_RUN` with the stop bit set moves to `PM_STOP`.
- **enter-halt**: a power write in `PM_RUN` with the stop bit clear and the halt bit set moves to `PM_HALT`.
- **stop-wake**: a synchronized stop event moves `PM_STOP` to `PM_OSCWAIT`.
- **halt-release**: an enabled, synchronized interrupt moves `PM_HALT` to `PM_OSCWAIT`.
- **osc-ready**: `PM_OSCWAIT` moves to `PM_RUN` when `osc_ready_i` is high.
- **reset**: any reset returns the block to `PM_RUN`.

Top module: `pm_wake_ctrl`

## Requirements
- R1: A reset clears the stop bit, the halt bit, the release mask and the status, and puts the block in `PM_RUN` with `osc_en_o`=1 and `cpu_clk_en_o`=1. The reset sources are `hw_rst_n_i` low, `por_n_i` low, or `lvd_en_i` and `lvd_below_i` both high. `chip_rst_o` is high while any reset source is active.
- R2: `lvd_below_i` has no effect while `lvd_en_i` is 0.
- R3: A power write (address 0x0200, stop bit = bit 1 set) in `PM_RUN` drives `osc_en_o`=0 and `cpu_clk_en_o`=0 from the next cycle.
- R4: A power write with bit 1 clear and the halt bit (bit 0) set enters halt: `osc_en_o`=1 and `cpu_clk_en_o`=0 from the next cycle.
- R5: A power write with bit 7 set is discarded entirely. Bits 6..2 of the power register, bits 7, 6 and 0 of the release register, and writes to any other address have no effect.
- R6: Stop mode is left when port 3, USB host reset or USB host resume is high. The halt-release interrupts for USB, timer 0, port 0.4 and port 0.5 do not wake it, whatever the mask holds.
- R7: Halt mode is left only by an interrupt whose bit is set in the release register (address 0x0202). The bits are: bit 1 USB, bit 2 timer 0, bit 3 port 3, bit 4 port 0.4, bit 5 port 0.5. Unmasked interrupts leave the block halted.
- R8: The wake takes effect `SYNC_STAGES`+1 cycles after the event is applied. From then, `osc_en_o`=1 and `cpu_clk_en_o` stays 0 until the cycle after `osc_ready_i` is seen high.
- R9: A halt-release ORs the enabled active sources into the sticky `rel_status_o` (bit 0 USB, bit 1 timer 0, bit 2 port 3, bit 3 port 0.4, bit 4 port 0.5). A stop-wake leaves it unchanged. `status_ack_i` clears it.
- R10: Register writes are accepted only in `PM_RUN`. While the CPU clock is gated, writes to either register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon_i | input | 1 | Always-on clock |
| hw_rst_n_i | input | 1 | Hardware reset, active low |
| por_n_i | input | 1 | Power-on reset, active low |
| lvd_en_i | input | 1 | Low-voltage detection enable |
| lvd_below_i | input | 1 | Supply below reset threshold |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | 8 | Write data |
| irq_usb_i | input | 1 | USB interrupt level |
| irq_tmr0_i | input | 1 | Timer 0 interrupt level |
| irq_p3_i | input | 1 | Port 3 interrupt level |
| irq_p04_i | input | 1 | Port 0.4 interrupt level |
| irq_p05_i | input | 1 | Port 0.5 interrupt level |
| usb_host_rst_i | input | 1 | USB host reset event level |
| usb_host_resume_i | input | 1 | USB host resume event level |
| osc_ready_i | input | 1 | Oscillator stable |
| status_ack_i | input | 1 | Clears the release status |
| chip_rst_o | output | 1 | Combined chip reset |
| osc_en_o | output | 1 | System oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| rel_status_o | output | 5 | Sticky halt-release sources |

## Verification
The hardest situation to reach is a sleep state with a set of inputs that must not wake it. Examples are halt with only masked interrupts active, stop with every halt interrupt enabled and active, and writes arriving while the CPU clock is gated. In each case the block stays asleep, and nothing on the outputs changes to show that the ignored inputs were seen. The bench therefore enters each sleep state through the register bus and holds the non-qualifying inputs for longer than the synchronizer delay. It then checks that the outputs are still asleep. It leaves the state again through a reset, which also confirms that the mask is cleared. Random masks and event subsets are mixed with these directed cases, and the expected wake decision comes from bench functions.

// File: rtl/pm_pkg.sv
package pm_pkg;
    // Controller states; run is encoded as zero
    typedef enum logic [1:0] {
        PM_RUN     = 2'd0,
        PM_HALT    = 2'd1,
        PM_STOP    = 2'd2,
        PM_OSCWAIT = 2'd3
    } pm_state_e;

    // Halt-release sources, vector order: usb, tmr0, p3, p04, p05
    localparam int NSRC   = 5;
    localparam int SRC_P3 = 2;
    localparam int NSTOP  = 3;

    localparam logic [15:0] PM_PWR_ADDR = 16'h0200;
    localparam logic [15:0] PM_REL_ADDR = 16'h0202;

    localparam int PWR_HALT_BIT = 0;
    localparam int PWR_CKC_BIT  = 1;
    localparam int PWR_LOCK_BIT = 7;
    localparam int REL_LSB      = 1;
endpackage

// File: rtl/pm_rst_combine.sv
module pm_rst_combine (
    input  logic hw_rst_n_i,
    input  logic por_n_i,
    input  logic lvd_en_i,
    input  logic lvd_below_i,
    output logic rst_o
);
    // Brown-out only counts when detection is switched on
    logic lvd_trip;

    always_comb begin
        lvd_trip = lvd_en_i && lvd_below_i;
        rst_o    = !hw_rst_n_i || !por_n_i || lvd_trip;
    end
endmodule

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [W-1:0] stage_q [STAGES];
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d_i;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign q_o = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pm_regs.sv
module pm_regs
    import pm_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_allow_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic              pwr_wr_o,
    output logic              pwr_ckc_o,
    output logic              pwr_halt_o,
    output logic [NSRC-1:0]   rel_mask_o
);
    localparam logic [ADDR_W-1:0] PWR_A = ADDR_W'(PM_PWR_ADDR);
    localparam logic [ADDR_W-1:0] REL_A = ADDR_W'(PM_REL_ADDR);

    logic pwr_hit, rel_hit;
    logic unused_bits;

    always_comb begin
        pwr_hit    = bus_wr_i && wr_allow_i && (bus_addr_i == PWR_A);
        rel_hit    = bus_wr_i && wr_allow_i && (bus_addr_i == REL_A);
        // A set lock bit voids the whole power write
        pwr_wr_o   = pwr_hit && !bus_wdata_i[PWR_LOCK_BIT];
        pwr_ckc_o  = bus_wdata_i[PWR_CKC_BIT];
        pwr_halt_o = bus_wdata_i[PWR_HALT_BIT];
    end

    assign unused_bits = bus_wdata_i[6];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rel_mask_o <= '0;
        end else if (rel_hit) begin
            rel_mask_o <= bus_wdata_i[REL_LSB +: NSRC];
        end
    end

    // R10: mask frozen while the CPU is not running
    a_r10_mask_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_allow_i |=> $stable(rel_mask_o));
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
    import pm_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             pwr_wr_i,
    input  logic             pwr_ckc_i,
    input  logic             pwr_halt_i,
    input  logic [NSRC-1:0]  rel_mask_i,
    input  logic [NSRC-1:0]  halt_src_i,
    input  logic [NSTOP-1:0] stop_evt_i,
    input  logic             osc_ready_i,
    input  logic             status_ack_i,
    output logic             osc_en_o,
    output logic             cpu_clk_en_o,
    output logic             wr_allow_o,
    output logic [NSRC-1:0]  rel_status_o
);
    pm_state_e       state_q, state_d;
    logic            ckc_q, ckc_d;
    logic            halt_q, halt_d;
    logic            wake, rel_fire;
    logic [NSRC-1:0] masked;
    logic [NSRC-1:0] status_q;

    assign masked = halt_src_i & rel_mask_i;

    // State register together with the two sleep bits
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PM_RUN;
            ckc_q   <= 1'b0;
            halt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ckc_q   <= ckc_d;
            halt_q  <= halt_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        ckc_d    = ckc_q;
        halt_d   = halt_q;
        wake     = 1'b0;
        rel_fire = 1'b0;
        unique case (state_q)
            PM_RUN: begin
                if (pwr_wr_i) begin
                    ckc_d  = pwr_ckc_i;
                    halt_d = pwr_halt_i;
                    if (pwr_ckc_i)       state_d = PM_STOP;
                    else if (pwr_halt_i) state_d = PM_HALT;
                end
            end
            PM_HALT: begin
                if (|masked) begin
                    wake     = 1'b1;
                    rel_fire = 1'b1;
                    state_d  = PM_OSCWAIT;
                end
            end
            PM_STOP: begin
                if (|stop_evt_i) begin
                    wake    = 1'b1;
                    state_d = PM_OSCWAIT;
                end
            end
            PM_OSCWAIT: begin
                if (osc_ready_i) state_d = PM_RUN;
            end
            default: state_d = PM_RUN;
        endcase
        if (wake) begin
            ckc_d  = 1'b0;
            halt_d = 1'b0;
        end
    end

    // Sticky release status
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            status_q <= '0;
        end else if (rel_fire) begin
            status_q <= (status_ack_i ? '0 : status_q) | masked;
        end else if (status_ack_i) begin
            status_q <= '0;
        end
    end

    // Outputs
    always_comb begin
        osc_en_o     = !ckc_q;
        cpu_clk_en_o = (state_q == PM_RUN) && !halt_q;
        wr_allow_o   = (state_q == PM_RUN);
        rel_status_o = status_q;
    end

    // R1: the cycle after a reset edge shows run mode with clean status
    logic rst_seen_q;
    always_ff @(posedge clk_i) rst_seen_q <= rst_i;
    always @(posedge clk_i) begin
        if (rst_seen_q) begin
            a_r1_reset_run: assert (osc_en_o && cpu_clk_en_o && status_q == '0);
        end
    end

    a_r3_stop_entry: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == PM_RUN && pwr_wr_i && pwr_ckc_i) |=> (!osc_en_o && !cpu_clk_en_o));

    a_r4_halt_entry: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == PM_RUN && pwr_wr_i && !pwr_ckc_i && pwr_halt_i) |=> (osc_en_o && !cpu_clk_en_o));

    a_r6_stop_wake: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == PM_STOP && |stop_evt_i) |=> (osc_en_o && !cpu_clk_en_o));

    a_r7_masked_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == PM_HALT && masked == '0) |=> (state_q == PM_HALT && !cpu_clk_en_o));

    a_r8_gate_after_osc: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cpu_clk_en_o) |-> $past(osc_ready_i));

    a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_ack_i && !rel_fire) |=> (rel_status_o == '0));
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
    import pm_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_aon_i,
    input  logic              hw_rst_n_i,
    input  logic              por_n_i,
    input  logic              lvd_en_i,
    input  logic              lvd_below_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    input  logic              irq_usb_i,
    input  logic              irq_tmr0_i,
    input  logic              irq_p3_i,
    input  logic              irq_p04_i,
    input  logic              irq_p05_i,
    input  logic              usb_host_rst_i,
    input  logic              usb_host_resume_i,
    input  logic              osc_ready_i,
    input  logic              status_ack_i,
    output logic              chip_rst_o,
    output logic              osc_en_o,
    output logic              cpu_clk_en_o,
    output logic [NSRC-1:0]   rel_status_o
);
    localparam int EV_W = NSRC + 2;

    logic            rst;
    logic            wr_allow;
    logic            pwr_wr, pwr_ckc, pwr_halt;
    logic [NSRC-1:0] rel_mask;
    logic [EV_W-1:0] ev_raw, ev_s;
    logic [NSTOP-1:0] stop_evt;

    assign ev_raw = {usb_host_resume_i, usb_host_rst_i,
                     irq_p05_i, irq_p04_i, irq_p3_i, irq_tmr0_i, irq_usb_i};
    assign stop_evt   = {ev_s[NSRC+1], ev_s[NSRC], ev_s[SRC_P3]};
    assign chip_rst_o = rst;

    pm_rst_combine u_rst (
        .hw_rst_n_i  (hw_rst_n_i),
        .por_n_i     (por_n_i),
        .lvd_en_i    (lvd_en_i),
        .lvd_below_i (lvd_below_i),
        .rst_o       (rst)
    );

    pm_sync #(.W(EV_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_aon_i),
        .rst_i (rst),
        .d_i   (ev_raw),
        .q_o   (ev_s)
    );

    pm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk_i       (clk_aon_i),
        .rst_i       (rst),
        .wr_allow_i  (wr_allow),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .pwr_wr_o    (pwr_wr),
        .pwr_ckc_o   (pwr_ckc),
        .pwr_halt_o  (pwr_halt),
        .rel_mask_o  (rel_mask)
    );

    pm_fsm u_fsm (
        .clk_i        (clk_aon_i),
        .rst_i        (rst),
        .pwr_wr_i     (pwr_wr),
        .pwr_ckc_i    (pwr_ckc),
        .pwr_halt_i   (pwr_halt),
        .rel_mask_i   (rel_mask),
        .halt_src_i   (ev_s[NSRC-1:0]),
        .stop_evt_i   (stop_evt),
        .osc_ready_i  (osc_ready_i),
        .status_ack_i (status_ack_i),
        .osc_en_o     (osc_en_o),
        .cpu_clk_en_o (cpu_clk_en_o),
        .wr_allow_o   (wr_allow),
        .rel_status_o (rel_status_o)
    );
endmodule

// File: tb/tb_pm_wake_ctrl.sv
`timescale 1ns/1ps
module tb_pm_wake_ctrl;
    localparam int SYNC = 2;
    localparam logic [15:0] A_PWR = 16'h0200;
    localparam logic [15:0] A_REL = 16'h0202;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic hw_rst_n = 1'b1, por_n = 1'b0, lvd_en = 1'b0, lvd_below = 1'b0;
    logic bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic irq_usb = 0, irq_tmr0 = 0, irq_p3 = 0, irq_p04 = 0, irq_p05 = 0;
    logic host_rst = 0, host_res = 0;
    logic osc_ready = 1'b1, ack = 1'b0;
    logic chip_rst, osc_en, cpu_en;
    logic [4:0] rel_status;

    int n_chk = 0, n_err = 0, cyc = 0;
    logic [4:0] status_m = '0;

    pm_wake_ctrl #(.ADDR_W(16), .SYNC_STAGES(SYNC)) dut (
        .clk_aon_i(clk), .hw_rst_n_i(hw_rst_n), .por_n_i(por_n),
        .lvd_en_i(lvd_en), .lvd_below_i(lvd_below),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .irq_usb_i(irq_usb), .irq_tmr0_i(irq_tmr0), .irq_p3_i(irq_p3),
        .irq_p04_i(irq_p04), .irq_p05_i(irq_p05),
        .usb_host_rst_i(host_rst), .usb_host_resume_i(host_res),
        .osc_ready_i(osc_ready), .status_ack_i(ack),
        .chip_rst_o(chip_rst), .osc_en_o(osc_en), .cpu_clk_en_o(cpu_en),
        .rel_status_o(rel_status)
    );

    function automatic logic halt_wakes(input logic [4:0] mask, input logic [4:0] irq);
        return |(mask & irq);
    endfunction

    function automatic logic stop_wakes(input logic [2:0] ev);
        return |ev;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_err++;
            $display("FAIL watchdog all-reqs actual=%0d expected<100000", cyc);
            finish_run();
        end
    end

    task automatic set_irq(input logic [4:0] v);
        {irq_p05, irq_p04, irq_p3, irq_tmr0, irq_usb} = v;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic hw_reset();
        @(negedge clk);
        hw_rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "chip_rst during hw reset", chip_rst, 1);
        hw_rst_n = 1'b1;
        status_m = '0;
        @(negedge clk);
        chk("R1", "osc_en after reset", osc_en, 1);
        chk("R1", "cpu_en after reset", cpu_en, 1);
        chk("R1", "status after reset", rel_status, 0);
    endtask

    task automatic run_halt(input logic [4:0] mask, input logic [4:0] irq);
        logic woke;
        bus_write(A_REL, {2'b00, mask, 1'b0});
        bus_write(A_PWR, 8'h01);
        chk("R4", "halt osc_en", osc_en, 1);
        chk("R4", "halt cpu_en", cpu_en, 0);
        set_irq(irq);
        repeat (SYNC + 2) @(negedge clk);
        woke = halt_wakes(mask, irq);
        chk("R7", "cpu_en after halt irq", cpu_en, woke);
        if (woke) status_m = status_m | (mask & irq);
        chk("R9", "release status", rel_status, status_m);
        set_irq('0);
        if (!woke) hw_reset();
        if ($urandom % 2 == 0) begin
            @(negedge clk); ack = 1'b1;
            @(negedge clk); ack = 1'b0;
            status_m = '0;
            chk("R9", "status after ack", rel_status, 0);
        end
        @(negedge clk);
    endtask

    task automatic run_stop(input logic [2:0] ev, input logic [3:0] others, input logic hbit);
        logic woke;
        bus_write(A_REL, 8'h3E);
        osc_ready = 1'b0;
        bus_write(A_PWR, {6'b0, 1'b1, hbit});
        chk("R3", "stop osc_en", osc_en, 0);
        chk("R3", "stop cpu_en", cpu_en, 0);
        irq_p3 = ev[0]; host_rst = ev[1]; host_res = ev[2];
        {irq_p05, irq_p04, irq_tmr0, irq_usb} = others;
        repeat (SYNC + 2) @(negedge clk);
        woke = stop_wakes(ev);
        chk("R6", "osc_en after stop events", osc_en, woke);
        chk("R8", "cpu gated before osc ready", cpu_en, 0);
        if (woke) begin
            repeat (3) @(negedge clk);
            chk("R8", "cpu still gated", cpu_en, 0);
            osc_ready = 1'b1;
            @(negedge clk);
            chk("R8", "cpu after osc ready", cpu_en, 1);
        end
        set_irq('0); host_rst = 1'b0; host_res = 1'b0;
        osc_ready = 1'b1;
        if (!woke) hw_reset();
        chk("R9", "status untouched by stop", rel_status, status_m);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Power-on reset
        repeat (3) @(negedge clk);
        chk("R1", "chip_rst during por", chip_rst, 1);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1", "chip_rst released", chip_rst, 0);
        chk("R1", "osc_en after por", osc_en, 1);
        chk("R1", "cpu_en after por", cpu_en, 1);
        chk("R1", "status after por", rel_status, 0);

        // R5: locked, unused and foreign writes
        bus_write(A_PWR, 8'h82);
        chk("R5", "bit7 write discarded osc", osc_en, 1);
        chk("R5", "bit7 write discarded cpu", cpu_en, 1);
        bus_write(16'h0201, 8'h03);
        chk("R5", "other address ignored", cpu_en, 1);
        bus_write(A_PWR, 8'h7C);
        chk("R5", "unused power bits", {osc_en, cpu_en}, 2'b11);
        // R5/R1: only unused release bits set, mask stays empty
        bus_write(A_REL, 8'hC1);
        bus_write(A_PWR, 8'h01);
        set_irq(5'h1F);
        repeat (SYNC + 4) @(negedge clk);
        chk("R5", "unused release bits give no wake", cpu_en, 0);
        set_irq('0);
        hw_reset();

        // R10: writes while halted
        run_halt(5'h00, 5'h00);
        bus_write(A_PWR, 8'h01);
        chk("R4", "halt entered", cpu_en, 0);
        bus_write(A_REL, 8'h3E);
        bus_write(A_PWR, 8'h00);
        set_irq(5'h1F);
        repeat (SYNC + 4) @(negedge clk);
        chk("R10", "writes during halt ignored", cpu_en, 0);
        set_irq('0);
        hw_reset();

        // R2: brown-out gated by enable
        bus_write(A_PWR, 8'h02);
        lvd_below = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2", "lvd disabled chip_rst", chip_rst, 0);
        chk("R2", "lvd disabled stays stopped", osc_en, 0);
        lvd_en = 1'b1;
        @(negedge clk);
        chk("R1", "lvd reset chip_rst", chip_rst, 1);
        chk("R1", "lvd reset osc_en", osc_en, 1);
        lvd_en = 1'b0; lvd_below = 1'b0;
        status_m = '0;
        @(negedge clk);
        chk("R1", "run after lvd reset", cpu_en, 1);

        // Directed corners
        run_halt(5'b00100, 5'b00100);
        run_halt(5'b10001, 5'b01110);
        run_stop(3'b010, 4'hF, 1'b1);
        run_stop(3'b000, 4'hF, 1'b0);

        // Constrained random
        for (int i = 0; i < 150; i++) begin
            if ($urandom % 3 == 0)
                run_stop(3'($urandom), 4'($urandom), 1'($urandom));
            else
                run_halt(5'($urandom), 5'($urandom) & 5'($urandom));
        end
        finish_run();
    end
endmodule